// File: doc/BRIEF.md
# Eight-Pin I/O Port with Peripheral Override Paths

This block is one general-purpose I/O port of eight pins. Software owns three registers per port: a direction byte, an output byte (which also requests the weak pull-up on pins that are inputs) and a read-only byte that returns the synchronized level seen on the pads. A shared write-data bus with one write strobe per writable register, and a shared read selector, reach all eight pins together. A sleep line and a global pull-up disable come from outside and are shared with every other port in the chip.

Peripherals that borrow a pin can take over part of its behaviour through paired enable/value override inputs. Each pin has such a pair for the pull-up, the driver direction, the driven level and the input gating. Each pin also has a toggle input that flips its stored output bit. An override always wins over the register state. The pad is modelled as separate drive-enable, drive-level and pull-up-request outputs plus a plain digital input. The gated pad level is also handed to peripherals unsynchronized, so a peripheral that uses it must resynchronize it itself.

The port holds no state machine. Its only state is the direction byte, the output byte and the two-stage input synchronizer. The result is one register block, a per-pin combinational override mux, and a synchronizer.

Top module: `gpio_ovr_port`

## Requirements
- R1: An active-low asynchronous reset clears the direction and output bytes, so every pin starts undriven with no pull-up requested, and both bytes read back as 0x00.
- R2: With the pull-up override enable of a pin low, `pad_pu_o` of that pin is 1 exactly when its direction bit is 0, its output bit is 1 and `pud_i` is 0.
- R3: With the pull-up override enable of a pin high, `pad_pu_o` of that pin equals its pull-up override value, whatever the direction bit, output bit and `pud_i` are.
- R4: `pad_oe_o` of a pin equals its direction override value when the direction override enable is high, and its direction bit otherwise.
- R5: While `pad_oe_o` of a pin is 1, `pad_do_o` equals the level override value if the level override enable is high, and the stored output bit otherwise. While `pad_oe_o` is 0, `pad_do_o` is 0.
- R6: Each rising edge with `tgl_ov_i[n]` high inverts stored output bit n once. When a write to the output byte happens on the same edge, the toggle inverts the newly written bit.
- R7: The input enable of a pin equals its input-enable override value when that override enable is high; otherwise it is 1 while `sleep_i` is 0 and 0 while `sleep_i` is 1. `af_din_o` equals the pad input ANDed with this enable, with no register in the path.
- R8: The pin readback byte (`rd_sel_i` = 3) is `af_din_o` delayed through two flops: a change on the pad appears on the second rising edge after it, and a pin whose input is disabled reads 0.
- R9: `dir_we_i` and `port_we_i` load the whole of `wdata_i` into the direction or the output byte on a rising edge. `rd_sel_i` = 1 returns the direction byte, 2 returns the output byte and 0 returns 0x00. Reads return the stored bits even while overrides change what the pads do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Chip sleep state, gates inputs that are not overridden |
| pud_i | input | 1 | Global pull-up disable |
| wdata_i | input | 8 | Shared register write data |
| dir_we_i | input | 1 | Write strobe for the direction byte |
| port_we_i | input | 1 | Write strobe for the output byte |
| rd_sel_i | input | 2 | Read selector: 0 none, 1 direction, 2 output, 3 pin readback |
| rdata_o | output | 8 | Selected register value |
| pu_ov_en_i | input | 8 | Per-pin pull-up override enable |
| pu_ov_val_i | input | 8 | Per-pin pull-up override value |
| dir_ov_en_i | input | 8 | Per-pin driver direction override enable |
| dir_ov_val_i | input | 8 | Per-pin driver direction override value |
| val_ov_en_i | input | 8 | Per-pin driven level override enable |
| val_ov_val_i | input | 8 | Per-pin driven level override value |
| tgl_ov_i | input | 8 | Per-pin toggle of the stored output bit |
| ie_ov_en_i | input | 8 | Per-pin input-enable override enable |
| ie_ov_val_i | input | 8 | Per-pin input-enable override value |
| pad_in_i | input | 8 | Digital level at each pad |
| pad_oe_o | output | 8 | Pad driver enable |
| pad_do_o | output | 8 | Pad driven level |
| pad_pu_o | output | 8 | Pad pull-up request |
| af_din_o | output | 8 | Gated, unsynchronized pad level for peripherals |

## Verification
The pad controls (R2 to R5) and `af_din_o` (R7) are combinational, so the bench checks them one nanosecond after the falling edge on which their inputs changed. Register effects (R6, R9) appear one rising edge after the strobe, so they are read back at the next falling edge. The pin readback (R8) is due two rising edges after the pad changes. The bench checks that the value has not arrived after the first edge and has arrived after the second. All stimulus is applied on falling edges, so no check ever samples near a rising edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Read selector encoding shared by the port and its bench
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_DIR  = 2'd1,
        RD_PORT = 2'd2,
        RD_PIN  = 2'd3
    } rd_sel_e;

    // Depth of the input synchronizer chain
    localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] wdata_i,
    input  logic         dir_we_i,
    input  logic         port_we_i,
    input  logic [W-1:0] tgl_i,
    output logic [W-1:0] dir_q_o,
    output logic [W-1:0] port_q_o
);

    logic [W-1:0] port_base;

    // A write supplies the new value; a toggle then inverts it bitwise
    assign port_base = port_we_i ? wdata_i : port_q_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q_o <= '0;
        end else if (dir_we_i) begin
            dir_q_o <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q_o <= '0;
        end else begin
            port_q_o <= port_base ^ tgl_i;
        end
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux (
    input  logic dir_bit_i,
    input  logic port_bit_i,
    input  logic pud_i,
    input  logic sleep_i,
    input  logic pu_ov_en_i,
    input  logic pu_ov_val_i,
    input  logic dir_ov_en_i,
    input  logic dir_ov_val_i,
    input  logic val_ov_en_i,
    input  logic val_ov_val_i,
    input  logic ie_ov_en_i,
    input  logic ie_ov_val_i,
    output logic oe_o,
    output logic do_o,
    output logic pu_o,
    output logic ie_o
);

    logic pu_reg_req;
    logic lvl_sel;

    // Register-based pull-up request: input pin, output bit set, not disabled
    assign pu_reg_req = ~dir_bit_i & port_bit_i & ~pud_i;

    always_comb begin
        pu_o    = pu_ov_en_i  ? pu_ov_val_i  : pu_reg_req;
        oe_o    = dir_ov_en_i ? dir_ov_val_i : dir_bit_i;
        lvl_sel = val_ov_en_i ? val_ov_val_i : port_bit_i;
        do_o    = oe_o & lvl_sel;
        ie_o    = ie_ov_en_i  ? ie_ov_val_i  : ~sleep_i;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
    import gpio_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep_i,
    input  logic         pud_i,
    input  logic [W-1:0] wdata_i,
    input  logic         dir_we_i,
    input  logic         port_we_i,
    input  logic [1:0]   rd_sel_i,
    output logic [W-1:0] rdata_o,
    input  logic [W-1:0] pu_ov_en_i,
    input  logic [W-1:0] pu_ov_val_i,
    input  logic [W-1:0] dir_ov_en_i,
    input  logic [W-1:0] dir_ov_val_i,
    input  logic [W-1:0] val_ov_en_i,
    input  logic [W-1:0] val_ov_val_i,
    input  logic [W-1:0] tgl_ov_i,
    input  logic [W-1:0] ie_ov_en_i,
    input  logic [W-1:0] ie_ov_val_i,
    input  logic [W-1:0] pad_in_i,
    output logic [W-1:0] pad_oe_o,
    output logic [W-1:0] pad_do_o,
    output logic [W-1:0] pad_pu_o,
    output logic [W-1:0] af_din_o
);

    logic [W-1:0] dir_q;
    logic [W-1:0] port_q;
    logic [W-1:0] pin_q;
    logic [W-1:0] ie_vec;
    logic [W-1:0] in_gated;
    rd_sel_e      rd_sel;

    gpio_port_regs #(.W(W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wdata_i   (wdata_i),
        .dir_we_i  (dir_we_i),
        .port_we_i (port_we_i),
        .tgl_i     (tgl_ov_i),
        .dir_q_o   (dir_q),
        .port_q_o  (port_q)
    );

    for (genvar n = 0; n < W; n++) begin : g_pin
        gpio_pin_mux mux_i (
            .dir_bit_i    (dir_q[n]),
            .port_bit_i   (port_q[n]),
            .pud_i        (pud_i),
            .sleep_i      (sleep_i),
            .pu_ov_en_i   (pu_ov_en_i[n]),
            .pu_ov_val_i  (pu_ov_val_i[n]),
            .dir_ov_en_i  (dir_ov_en_i[n]),
            .dir_ov_val_i (dir_ov_val_i[n]),
            .val_ov_en_i  (val_ov_en_i[n]),
            .val_ov_val_i (val_ov_val_i[n]),
            .ie_ov_en_i   (ie_ov_en_i[n]),
            .ie_ov_val_i  (ie_ov_val_i[n]),
            .oe_o         (pad_oe_o[n]),
            .do_o         (pad_do_o[n]),
            .pu_o         (pad_pu_o[n]),
            .ie_o         (ie_vec[n])
        );
    end

    // Gate before synchronizing so a disabled input never toggles the flops
    assign in_gated = pad_in_i & ie_vec;
    assign af_din_o = in_gated;

    gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (in_gated),
        .q_o   (pin_q)
    );

    assign rd_sel = rd_sel_e'(rd_sel_i);

    always_comb begin
        unique case (rd_sel)
            RD_DIR:  rdata_o = dir_q;
            RD_PORT: rdata_o = port_q;
            RD_PIN:  rdata_o = pin_q;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sleep_i,
    input logic         pud_i,
    input logic [W-1:0] wdata_i,
    input logic         dir_we_i,
    input logic         port_we_i,
    input logic [W-1:0] tgl_ov_i,
    input logic [W-1:0] pu_ov_en_i,
    input logic [W-1:0] dir_ov_en_i,
    input logic [W-1:0] ie_ov_en_i,
    input logic [W-1:0] pad_oe_o,
    input logic [W-1:0] pad_do_o,
    input logic [W-1:0] pad_pu_o,
    input logic [W-1:0] af_din_o,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] port_q,
    input logic [W-1:0] pin_q
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        dir_we_i |=> dir_q == $past(wdata_i)); // R9

    AST_PORT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !port_we_i |=> port_q == $past(port_q ^ tgl_ov_i)); // R6

    AST_PORT_WRITE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        port_we_i |=> port_q == $past(wdata_i ^ tgl_ov_i)); // R6

    AST_NO_LEVEL_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_do_o & ~pad_oe_o) == '0); // R5

    AST_PU_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pud_i |-> (pad_pu_o & ~pu_ov_en_i) == '0); // R2

    AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_o & ~pu_ov_en_i & ~dir_ov_en_i & pad_oe_o) == '0); // R2

    AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> (af_din_o & ~ie_ov_en_i) == '0); // R7

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> pin_q == $past(af_din_o, 2)); // R8

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (dir_q == '0 && port_q == '0)); // R1

endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .pud_i       (pud_i),
    .wdata_i     (wdata_i),
    .dir_we_i    (dir_we_i),
    .port_we_i   (port_we_i),
    .tgl_ov_i    (tgl_ov_i),
    .pu_ov_en_i  (pu_ov_en_i),
    .dir_ov_en_i (dir_ov_en_i),
    .ie_ov_en_i  (ie_ov_en_i),
    .pad_oe_o    (pad_oe_o),
    .pad_do_o    (pad_do_o),
    .pad_pu_o    (pad_pu_o),
    .af_din_o    (af_din_o),
    .dir_q       (dir_q),
    .port_q      (port_q),
    .pin_q       (pin_q)
);

// File: tb/gpio_ovr_port_tb_top.sv
`timescale 1ns/1ps
module gpio_ovr_port_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sleep_i = 1'b0;
    logic         pud_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic         dir_we_i = 1'b0;
    logic         port_we_i = 1'b0;
    logic [1:0]   rd_sel_i = 2'd0;
    logic [W-1:0] rdata_o;
    logic [W-1:0] pu_ov_en_i = '0, pu_ov_val_i = '0;
    logic [W-1:0] dir_ov_en_i = '0, dir_ov_val_i = '0;
    logic [W-1:0] val_ov_en_i = '0, val_ov_val_i = '0;
    logic [W-1:0] tgl_ov_i = '0;
    logic [W-1:0] ie_ov_en_i = '0, ie_ov_val_i = '0;
    logic [W-1:0] pad_in_i = '0;
    logic [W-1:0] pad_oe_o, pad_do_o, pad_pu_o, af_din_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_ovr_port #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .pud_i(pud_i),
        .wdata_i(wdata_i), .dir_we_i(dir_we_i), .port_we_i(port_we_i),
        .rd_sel_i(rd_sel_i), .rdata_o(rdata_o),
        .pu_ov_en_i(pu_ov_en_i), .pu_ov_val_i(pu_ov_val_i),
        .dir_ov_en_i(dir_ov_en_i), .dir_ov_val_i(dir_ov_val_i),
        .val_ov_en_i(val_ov_en_i), .val_ov_val_i(val_ov_val_i),
        .tgl_ov_i(tgl_ov_i), .ie_ov_en_i(ie_ov_en_i), .ie_ov_val_i(ie_ov_val_i),
        .pad_in_i(pad_in_i), .pad_oe_o(pad_oe_o), .pad_do_o(pad_do_o),
        .pad_pu_o(pad_pu_o), .af_din_o(af_din_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [W-1:0] v);
        rd_sel_i = sel;
        #1;
        v = rdata_o;
    endtask

    task automatic wr_dir(input logic [W-1:0] v);
        @(negedge clk); dir_we_i = 1'b1; wdata_i = v;
        @(negedge clk); dir_we_i = 1'b0;
    endtask

    task automatic wr_port(input logic [W-1:0] v);
        @(negedge clk); port_we_i = 1'b1; wdata_i = v;
        @(negedge clk); port_we_i = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] dv, pv, e_pu, e_oe, e_do, e_ie;
        logic [7:0]   c;
        logic [2:0]   c3;

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1 oe in reset", pad_oe_o, '0);
        chk("R1 pu in reset", pad_pu_o, '0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd1, v); chk("R1 dir after reset", v, '0);
        rd(2'd2, v); chk("R1 port after reset", v, '0);
        rd(2'd0, v); chk("R9 no selection", v, '0);

        // R2..R5, R9: sweep of register bits and overrides per pin
        for (int n = 0; n < 512; n++) begin
            for (int i = 0; i < W; i++) begin
                c = 8'(n + i * 37);
                dv[i] = c[0]; pv[i] = c[1];
                pu_ov_en_i[i]  = c[2]; pu_ov_val_i[i]  = c[3];
                dir_ov_en_i[i] = c[4]; dir_ov_val_i[i] = c[5];
                val_ov_en_i[i] = c[6]; val_ov_val_i[i] = c[7];
            end
            pud_i = n[8];
            wr_dir(dv);
            wr_port(pv);
            #1;
            e_pu = (pu_ov_en_i & pu_ov_val_i) | (~pu_ov_en_i & ~dv & pv & {W{~pud_i}});
            e_oe = (dir_ov_en_i & dir_ov_val_i) | (~dir_ov_en_i & dv);
            e_do = e_oe & ((val_ov_en_i & val_ov_val_i) | (~val_ov_en_i & pv));
            chk((pu_ov_en_i == '0) ? "R2 pull-up" : "R3 pull-up override", pad_pu_o, e_pu);
            chk("R4 driver enable", pad_oe_o, e_oe);
            chk("R5 driven level", pad_do_o, e_do);
            rd(2'd1, v); chk("R9 dir readback under overrides", v, dv);
            rd(2'd2, v); chk("R9 port readback under overrides", v, pv);
        end
        pu_ov_en_i = '0; dir_ov_en_i = '0; val_ov_en_i = '0; pud_i = 1'b0;

        // R6: toggle once per asserted edge
        wr_port(8'hA5);
        @(negedge clk); tgl_ov_i = 8'h0F;
        repeat (3) @(negedge clk);
        tgl_ov_i = '0;
        rd(2'd2, v); chk("R6 three toggles", v, 8'hAA);
        @(negedge clk); tgl_ov_i = 8'hF0;
        @(negedge clk); tgl_ov_i = '0;
        rd(2'd2, v); chk("R6 single toggle", v, 8'h5A);
        @(negedge clk); port_we_i = 1'b1; wdata_i = 8'h3C; tgl_ov_i = 8'h81;
        @(negedge clk); port_we_i = 1'b0; tgl_ov_i = '0;
        rd(2'd2, v); chk("R6 write with toggle", v, 8'hBD);
        wr_dir(8'hFF);
        #1; chk("R6 toggled bit drives pad", pad_do_o, 8'hBD);
        wr_dir(8'h00);

        // R7, R8: input enable sweep and readback
        for (int m = 0; m < 16; m++) begin
            @(negedge clk);
            sleep_i = m[3];
            for (int i = 0; i < W; i++) begin
                c3 = 3'(m + i * 3);
                ie_ov_en_i[i] = c3[0]; ie_ov_val_i[i] = c3[1]; pad_in_i[i] = c3[2];
            end
            #1;
            e_ie = (ie_ov_en_i & ie_ov_val_i) | (~ie_ov_en_i & {W{~sleep_i}});
            chk("R7 peripheral input gating", af_din_o, pad_in_i & e_ie);
            repeat (2) @(negedge clk);
            rd(2'd3, v); chk("R8 pin readback gated", v, pad_in_i & e_ie);
        end

        // R8: two-edge latency
        sleep_i = 1'b0; ie_ov_en_i = '0;
        @(negedge clk); pad_in_i = '0;
        repeat (3) @(negedge clk);
        pad_in_i = 8'hC3;
        @(negedge clk);
        rd(2'd3, v); chk("R8 not yet after one edge", v, 8'h00);
        @(negedge clk);
        rd(2'd3, v); chk("R8 arrived after two edges", v, 8'hC3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule